// File: doc/BRIEF.md
# Indexed Control Register Port

This block sits on the byte-wide register bus of an audio board and shares a small group of ports with an external synthesizer. Normally every access passes straight through to the synthesizer. Writing the value 0xFF to port 2 switches the block into control mode, and writing 0xFE switches it back. While control mode is active, port 2 holds a register index and port 3 reads or writes the register at that index. There are 25 registers.

The block keeps a second, shadow copy of all 25 settings, standing in for non-volatile storage. A command written to register 0 copies the whole array from the shadow into the live registers, or from the live registers into the shadow. The live registers are decoded into the values the mixer needs: master volume in dB with a mute flag, bass and treble codes, and signed synthesizer and sample gains. Every bus access is decoded in the cycle it is presented. Read data is combinational, and writes take effect at the next clock edge.

Top module: `audio_ctl_regport`

## Requirements
- R1: A write of 0xFF to port 2 turns control mode on, and a write of 0xFE to port 2 turns it off. This holds whatever the current mode is. Neither value is forwarded, and neither value changes the register index.
- R2: In control mode, any other write to port 2 stores the byte as the register index. A write to port 3 at an index from 1 to 24 stores the byte in that live register, and a read of port 3 at that index returns it.
- R3: In control mode, a write to port 3 at an index of 25 or above changes no register, and a read of port 3 at such an index returns 0xFF.
- R4: A write to register 0 with bit 0 set copies all 25 shadow bytes into the live registers. With only bit 1 set, it copies the live registers into the shadow. With both bits set, the live registers take the shadow values and the shadow keeps its contents.
- R5: In control mode, a read of register 0 returns 0x50 when `surround_fitted` is 1 and 0x70 when it is 0.
- R6: In control mode, a read of port 2 returns {4'b0000, `irq_n`}, where `irq_n` is the 4-bit active-low interrupt status.
- R7: When control mode is off, or when the port is not 2 or 3, the bus address, write data and strobes are presented on the forward outputs in the same cycle, and `rdata` equals `fwd_rdata`. In control mode, accesses to ports 2 and 3 raise no forward strobe.
- R8: Registers 4 (left) and 5 (right) hold the master volume in their low 6 bits. For a code c of 0x1C or above, the volume output is 2*c-120 dB: code 0x3F gives +6 and code 0x1C gives -64. For a code below 0x1C, the mute output is 1 and the dB output reads -128.
- R9: Registers 6 and 7 give the bass and treble codes from their low 4 bits; code 6 means flat. Registers 9 and 10 give the left and right synthesizer gains, and registers 11 and 12 give the left and right sample gains. Each gain is the register value minus 128, as a signed 8-bit number.
- R10: After reset, control mode is off and the index is 0. Both the shadow and the live registers hold 0x71 at index 0x13 (interrupt 7 in the high nibble, DMA 1 in the low nibble), 0x03 at index 0x14 (DMA 3), and 0x71 at index 0x15 (base address 0x388 divided by 8). Every other byte is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 3 | Port number of the access |
| wdata | input | 8 | Write data |
| wr | input | 1 | Write strobe, one access per cycle |
| rd | input | 1 | Read strobe |
| rdata | output | 8 | Read data, valid in the cycle `rd` is high |
| surround_fitted | input | 1 | 1 when the surround option is fitted |
| irq_n | input | 4 | Active-low interrupt status |
| fwd_addr | output | 3 | Forwarded port number |
| fwd_wdata | output | 8 | Forwarded write data |
| fwd_wr | output | 1 | Forwarded write strobe |
| fwd_rd | output | 1 | Forwarded read strobe |
| fwd_rdata | input | 8 | Read data returned by the synthesizer |
| vol_l_db | output | 8 | Left master volume in dB, signed |
| vol_r_db | output | 8 | Right master volume in dB, signed |
| vol_l_mute | output | 1 | Left master volume is muted |
| vol_r_mute | output | 1 | Right master volume is muted |
| bass | output | 4 | Bass code |
| treble | output | 4 | Treble code |
| fm_gain_l | output | 8 | Left synthesizer gain, signed |
| fm_gain_r | output | 8 | Right synthesizer gain, signed |
| smp_gain_l | output | 8 | Left sample gain, signed |
| smp_gain_r | output | 8 | Right sample gain, signed |

## Verification
The bench enters control mode again while already in it and checks that the index is unchanged. A design that stored the magic byte as the index would read the wrong register afterwards. It writes to index 0x24, whose low bits alias register 4, and reads register 4 back. A design that masked the index would overwrite a live register there. The bench runs a copy with both command bits set and then reloads from the shadow, which shows whether the shadow was overwritten in the same write. It also checks the volume codes at both edges of the mute threshold, and writes data whose upper bits are set to show that those bits are masked off.

// File: rtl/audio_ctl_regport.sv
module audio_ctl_regport #(
  parameter int NREG = 25,
  parameter logic [7:0] ENTER_CODE = 8'hFF,
  parameter logic [7:0] LEAVE_CODE = 8'hFE
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] addr,
  input  logic [7:0] wdata,
  input  logic       wr,
  input  logic       rd,
  output logic [7:0] rdata,
  input  logic       surround_fitted,
  input  logic [3:0] irq_n,
  output logic [2:0] fwd_addr,
  output logic [7:0] fwd_wdata,
  output logic       fwd_wr,
  output logic       fwd_rd,
  input  logic [7:0] fwd_rdata,
  output logic [7:0] vol_l_db,
  output logic [7:0] vol_r_db,
  output logic       vol_l_mute,
  output logic       vol_r_mute,
  output logic [3:0] bass,
  output logic [3:0] treble,
  output logic [7:0] fm_gain_l,
  output logic [7:0] fm_gain_r,
  output logic [7:0] smp_gain_l,
  output logic [7:0] smp_gain_r
);
  localparam int IW = $clog2(NREG);

  logic       ctl_on;
  logic [7:0] idx;
  logic [7:0] live   [NREG];
  logic [7:0] shadow [NREG];

  function automatic logic [7:0] boot_val(input int i);
    case (i)
      8'h13:   return 8'h71;
      8'h14:   return 8'h03;
      8'h15:   return 8'h71;
      default: return 8'h00;
    endcase
  endfunction

  wire ctl_port  = (addr == 3'd2) || (addr == 3'd3);
  wire fwd_sel   = !ctl_on || !ctl_port;
  wire is_magic  = (addr == 3'd2) && (wdata == ENTER_CODE || wdata == LEAVE_CODE);
  wire idx_ok    = idx < 8'(NREG);
  wire [IW-1:0] sel = idx[IW-1:0];

  assign fwd_addr  = addr;
  assign fwd_wdata = wdata;
  assign fwd_wr    = wr && fwd_sel && !is_magic;
  assign fwd_rd    = rd && fwd_sel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_on <= 1'b0;
      idx    <= 8'h00;
      for (int i = 0; i < NREG; i++) begin
        live[i]   <= boot_val(i);
        shadow[i] <= boot_val(i);
      end
    end else if (wr) begin
      if (addr == 3'd2 && wdata == ENTER_CODE)
        ctl_on <= 1'b1;
      else if (addr == 3'd2 && wdata == LEAVE_CODE)
        ctl_on <= 1'b0;
      else if (ctl_on && addr == 3'd2)
        idx <= wdata;
      else if (ctl_on && addr == 3'd3 && idx_ok) begin
        if (idx == 8'h00) begin
          for (int i = 0; i < NREG; i++) begin
            if (wdata[0]) live[i] <= shadow[i];
            if (wdata[1] && !wdata[0]) shadow[i] <= live[i];
          end
        end else begin
          live[sel] <= wdata;
        end
      end
    end
  end

  always_comb begin
    if (fwd_sel)              rdata = fwd_rdata;
    else if (addr == 3'd2)    rdata = {4'h0, irq_n};
    else if (!idx_ok)         rdata = 8'hFF;
    else if (idx == 8'h00)    rdata = surround_fitted ? 8'h50 : 8'h70;
    else                      rdata = live[sel];
  end

  assign vol_l_mute = live[4][5:0] < 6'h1C;
  assign vol_r_mute = live[5][5:0] < 6'h1C;
  assign vol_l_db   = vol_l_mute ? 8'h80 : {1'b0, live[4][5:0], 1'b0} - 8'd120;
  assign vol_r_db   = vol_r_mute ? 8'h80 : {1'b0, live[5][5:0], 1'b0} - 8'd120;
  assign bass       = live[6][3:0];
  assign treble     = live[7][3:0];
  assign fm_gain_l  = live[9]  - 8'd128;
  assign fm_gain_r  = live[10] - 8'd128;
  assign smp_gain_l = live[11] - 8'd128;
  assign smp_gain_r = live[12] - 8'd128;
endmodule

module audio_ctl_regport_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] addr,
  input logic [7:0] wdata,
  input logic       wr,
  input logic       rd,
  input logic [7:0] rdata,
  input logic       surround_fitted,
  input logic       fwd_wr,
  input logic       fwd_rd,
  input logic       ctl_on,
  input logic [7:0] idx
);
  p_enter_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr && addr == 3'd2 && wdata == 8'hFF |=> ctl_on);
  p_leave_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr && addr == 3'd2 && wdata == 8'hFE |=> !ctl_on);
  p_magic_keeps_idx_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr && addr == 3'd2 && (wdata == 8'hFF || wdata == 8'hFE) |=> $stable(idx));
  p_magic_no_fwd_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr && addr == 3'd2 && (wdata == 8'hFF || wdata == 8'hFE) |-> !fwd_wr);
  p_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_on && rd && addr == 3'd3 && idx >= 8'd25 |-> rdata == 8'hFF);
  p_id_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_on && rd && addr == 3'd3 && idx == 8'd0 |-> rdata == (surround_fitted ? 8'h50 : 8'h70));
  p_ctl_no_fwd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_on && (addr == 3'd2 || addr == 3'd3) |-> !fwd_wr && !fwd_rd);
  p_pass_rd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_on && rd |-> fwd_rd);
endmodule

bind audio_ctl_regport audio_ctl_regport_chk u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr(wr), .rd(rd),
  .rdata(rdata), .surround_fitted(surround_fitted), .fwd_wr(fwd_wr),
  .fwd_rd(fwd_rd), .ctl_on(ctl_on), .idx(idx)
);

// File: tb/tb_audio_ctl_regport.sv
`timescale 1ns/1ps
module tb_audio_ctl_regport;
  logic clk = 0, rst_n = 0;
  logic [2:0] addr = 0;
  logic [7:0] wdata = 0;
  logic wr = 0, rd = 0, surround_fitted = 0;
  logic [3:0] irq_n = 4'hA;
  logic [7:0] fwd_rdata = 8'hA5;
  logic [7:0] rdata, fwd_wdata, vol_l_db, vol_r_db;
  logic [7:0] fm_gain_l, fm_gain_r, smp_gain_l, smp_gain_r;
  logic [2:0] fwd_addr;
  logic fwd_wr, fwd_rd, vol_l_mute, vol_r_mute;
  logic [3:0] bass, treble;

  int errors = 0, checks = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];
  logic seen_fwd_wr;
  logic [2:0] seen_fwd_addr;

  always #2.5 clk = ~clk;

  audio_ctl_regport dut (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rd && rst_n) begin
    if (exp_q.size() == 0) check("queue empty", 1, 0);
    else check(tag_q.pop_front(), rdata, exp_q.pop_front());
  end

  task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
    @(posedge clk); #1 addr = a; wdata = d; wr = 1;
    @(negedge clk); seen_fwd_wr = fwd_wr; seen_fwd_addr = fwd_addr;
    @(posedge clk); #1 wr = 0;
  endtask

  task automatic bus_rd(input logic [2:0] a, input logic [7:0] e, input string tag);
    @(posedge clk); #1 addr = a; rd = 1; exp_q.push_back(e); tag_q.push_back(tag);
    @(posedge clk); #1 rd = 0;
  endtask

  task automatic reg_wr(input logic [7:0] i, input logic [7:0] d);
    bus_wr(3'd2, i); bus_wr(3'd3, d);
  endtask

  task automatic reg_rd(input logic [7:0] i, input logic [7:0] e, input string tag);
    bus_wr(3'd2, i); bus_rd(3'd3, e, tag);
  endtask

  initial begin
    #(200000 * 5);
    check("watchdog", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check("R10 reset vol_l mute", vol_l_mute, 1);
    check("R10 reset vol_l_db", vol_l_db, 8'h80);
    bus_rd(3'd2, 8'hA5, "R10 R7 mode off forwards port2 read");

    bus_wr(3'd2, 8'hFF);
    check("R1 enter code not forwarded", seen_fwd_wr, 0);
    bus_rd(3'd2, 8'h0A, "R6 status read");
    reg_rd(8'h13, 8'h71, "R10 boot 0x13");
    reg_rd(8'h14, 8'h03, "R10 boot 0x14");
    reg_rd(8'h15, 8'h71, "R10 boot 0x15");
    reg_rd(8'h00, 8'h70, "R5 id no surround");
    surround_fitted = 1;
    bus_rd(3'd3, 8'h50, "R5 id surround");

    bus_wr(3'd0, 8'h12);
    check("R7 port0 forwarded in ctl mode", seen_fwd_wr, 1);
    check("R7 forwarded addr", seen_fwd_addr, 0);
    bus_wr(3'd3, 8'h12);
    check("R7 port3 not forwarded in ctl mode", seen_fwd_wr, 0);

    reg_wr(8'h04, 8'h7F);
    @(negedge clk);
    check("R8 vol_l +6 dB", vol_l_db, 8'd6);
    check("R8 vol_l not muted", vol_l_mute, 0);
    reg_rd(8'h04, 8'h7F, "R2 readback reg4");
    reg_wr(8'h05, 8'h1C);
    @(negedge clk);
    check("R8 vol_r -64 dB", vol_r_db, 8'hC0);
    check("R8 vol_r 0x1C not muted", vol_r_mute, 0);
    reg_wr(8'h05, 8'h1B);
    @(negedge clk);
    check("R8 vol_r 0x1B muted", vol_r_mute, 1);

    reg_wr(8'h06, 8'hF6);
    reg_wr(8'h07, 8'h2A);
    reg_wr(8'h09, 8'h80);
    reg_wr(8'h0A, 8'h00);
    reg_wr(8'h0B, 8'hFF);
    reg_wr(8'h0C, 8'h90);
    @(negedge clk);
    check("R9 bass", bass, 4'h6);
    check("R9 treble", treble, 4'hA);
    check("R9 fm_gain_l", fm_gain_l, 8'h00);
    check("R9 fm_gain_r", fm_gain_r, 8'h80);
    check("R9 smp_gain_l", smp_gain_l, 8'h7F);
    check("R9 smp_gain_r", smp_gain_r, 8'h10);

    reg_wr(8'h19, 8'h55);
    bus_rd(3'd3, 8'hFF, "R3 index 0x19 reads FF");
    reg_wr(8'h24, 8'h55);
    bus_rd(3'd3, 8'hFF, "R3 index 0x24 reads FF");
    reg_rd(8'h04, 8'h7F, "R3 aliased write ignored");

    reg_wr(8'h13, 8'h11);
    reg_wr(8'h00, 8'h02);
    reg_wr(8'h13, 8'h22);
    reg_rd(8'h13, 8'h22, "R2 live 0x13 written");
    reg_wr(8'h00, 8'h01);
    reg_rd(8'h13, 8'h11, "R4 shadow to live");
    reg_wr(8'h13, 8'h33);
    reg_wr(8'h00, 8'h03);
    reg_rd(8'h13, 8'h11, "R4 both bits live gets shadow");
    reg_wr(8'h13, 8'h44);
    reg_wr(8'h00, 8'h01);
    reg_rd(8'h13, 8'h11, "R4 both bits shadow kept");

    bus_wr(3'd2, 8'h06);
    bus_wr(3'd2, 8'hFF);
    bus_rd(3'd3, 8'hF6, "R1 enter code not stored as index");
    bus_wr(3'd2, 8'hFE);
    check("R1 leave code not forwarded", seen_fwd_wr, 0);
    bus_rd(3'd2, 8'hA5, "R1 R7 after leave port2 forwarded");
    bus_wr(3'd3, 8'h12);
    check("R7 port3 forwarded when off", seen_fwd_wr, 1);
    bus_wr(3'd2, 8'hFF);
    bus_rd(3'd3, 8'hF6, "R1 leave code not stored as index");

    repeat (2) @(posedge clk);
    if (exp_q.size() != 0) check("R2 pending reads", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule